// File: doc/BRIEF.md
# Dual-channel interrupt vector priority encoder

This block sits between two serial channels and the host's interrupt logic. Each channel supplies four interrupt causes as levels: transmit buffer empty, external/status change, receive character available and special receive condition. Per-channel enables decide which causes count. Among the causes that survive, the block picks one winner by a fixed ranking and raises a single interrupt request.

The host answers the request by reading the vector. That read captures the vector as it stands in that cycle and marks the interrupt as in service. The request then stays low until an end-of-interrupt command releases the lock. The vector is built from a shared base value. When the winning channel has its status-affects-vector option set, the low bits of the vector are replaced by a code that names the channel and the cause. A pending flag shows whether any enabled cause exists, whether or not an interrupt is in service.

Top module: `intvec_prio`

## Requirements
- R1: A cause counts as eligible only when its channel enable is set. Transmit buffer empty is enabled by `tx_ie_i`, external/status change by `ext_ie_i`, and both receive causes by `rx_ie_i`. A disabled cause has no effect on `pend_o`, `irq_o` or the vector.
- R2: `pend_o` is high in the cycle after a clock edge at which at least one eligible cause was present, and low otherwise.
- R3: `irq_o` is high in the cycle after a clock edge at which an eligible cause was present and no interrupt was in service (or entering service). It is never high while `pend_o` is low.
- R4: The cause code is channel index × 4 + cause number. The cause numbers are: transmit buffer empty 0, external/status change 1, receive character available 2, special receive condition 3. With two channels, channel A is index 1 (codes 4 to 7) and channel B is index 0 (codes 0 to 3).
- R5: With `rx_first_i` = 0 the order within a rank is transmit buffer empty, then special receive, then receive available, then external/status. With `rx_first_i` = 1 it is special receive, then receive available, then transmit buffer empty, then external/status.
- R6: At equal rank the higher channel index wins, so channel A outranks channel B.
- R7: If the winner's `sav_i` bit is set, the vector is `vec_base_i` with bits [2:0] replaced by the code. If that bit is clear, or no cause is eligible, the vector equals `vec_base_i`.
- R8: A cycle with `vec_rd_i` high captures the vector, which appears on `vec_o` after the next clock edge. `vec_o` then holds that value until the next read, whatever the causes do.
- R9: A read while an eligible cause exists puts the block in service. `irq_o` is then low from the next cycle on, until an end-of-interrupt command arrives.
- R10: `eoi_i` releases the in-service state, and `irq_o` returns in the next cycle if a cause is still eligible. When `vec_rd_i` and `eoi_i` are high in the same cycle, the read wins and the block stays in service.
- R11: While `rst_n` is low, `irq_o`, `pend_o` and `vec_o` are zero and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_empty_i | input | NCH | Transmit buffer empty cause, one bit per channel |
| ext_chg_i | input | NCH | External/status change cause |
| rx_avail_i | input | NCH | Receive character available cause |
| rx_special_i | input | NCH | Special receive condition cause |
| tx_ie_i | input | NCH | Transmit interrupt enable |
| rx_ie_i | input | NCH | Receive interrupt enable (both receive causes) |
| ext_ie_i | input | NCH | External/status interrupt enable |
| sav_i | input | NCH | Status-affects-vector enable |
| rx_first_i | input | 1 | Rank receive causes above transmit |
| vec_base_i | input | VEC_W | Shared vector base |
| vec_rd_i | input | 1 | Host vector read (acknowledge) strobe |
| eoi_i | input | 1 | End-of-interrupt command strobe |
| irq_o | output | 1 | Interrupt request |
| pend_o | output | 1 | Any eligible cause pending |
| vec_o | output | VEC_W | Latched interrupt vector |

## Verification
Every output is one register away from its inputs. `pend_o` and `irq_o` reflect the causes, enables, read and end-of-interrupt seen at one rising edge, and `vec_o` shows the vector captured at the edge where the read was sampled. The bench therefore drives all inputs on the falling edge and computes the expected next state from those inputs. It lets exactly one rising edge pass and compares all three outputs on the following falling edge. Directed cases that compare against literal vector values use the same one-edge spacing after the read cycle.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

   // Cause numbers; these are also the low two bits of the vector code (R4)
   typedef enum logic [1:0] {
      CS_TX  = 2'd0,
      CS_EXT = 2'd1,
      CS_RXA = 2'd2,
      CS_RXS = 2'd3
   } cause_e;

   localparam int unsigned NUM_CAUSE = 4;

   // Cause that occupies a given rank (0 = highest) for the chosen order (R5)
   function automatic cause_e cause_at_rank(input logic [1:0] rank, input logic rx_first);
      cause_e c;
      if (rx_first) begin
         case (rank)
            2'd0:    c = CS_RXS;
            2'd1:    c = CS_RXA;
            2'd2:    c = CS_TX;
            default: c = CS_EXT;
         endcase
      end else begin
         case (rank)
            2'd0:    c = CS_TX;
            2'd1:    c = CS_RXS;
            2'd2:    c = CS_RXA;
            default: c = CS_EXT;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/intvec_gate.sv
module intvec_gate (
   input  logic       tx_empty,
   input  logic       ext_chg,
   input  logic       rx_avail,
   input  logic       rx_special,
   input  logic       tx_ie,
   input  logic       rx_ie,
   input  logic       ext_ie,
   output logic [3:0] elig
);
   import intvec_pkg::*;

   always_comb begin
      elig         = '0;
      elig[CS_TX]  = tx_empty   & tx_ie;
      elig[CS_EXT] = ext_chg    & ext_ie;
      elig[CS_RXA] = rx_avail   & rx_ie;
      elig[CS_RXS] = rx_special & rx_ie;
   end

endmodule

// File: rtl/intvec_arb.sv
module intvec_arb #(
   parameter int unsigned NCH  = 2,
   parameter int unsigned CH_W = 1
) (
   input  logic [NCH-1:0][3:0] elig,
   input  logic                rx_first,
   output logic                valid,
   output logic [CH_W-1:0]     win_ch,
   output logic [1:0]          win_cause,
   output logic [NCH*4-1:0]    grant
);
   import intvec_pkg::*;

   always_comb begin
      cause_e c;
      valid     = 1'b0;
      win_ch    = '0;
      win_cause = '0;
      grant     = '0;
      for (int r = 0; r < 4; r++) begin
         c = cause_at_rank(2'(r), rx_first);
         for (int ch = NCH - 1; ch >= 0; ch--) begin
            if (!valid && elig[ch][c]) begin
               valid                  = 1'b1;
               win_ch                 = CH_W'(ch);
               win_cause              = c;
               grant[ch*4 + int'(c)]  = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_elig,
   input  logic [VEC_W-1:0] live_vec,
   input  logic             vec_rd,
   input  logic             eoi,
   output logic             irq,
   output logic             pend,
   output logic [VEC_W-1:0] vec
);
   logic ins_q, ins_d;

   always_comb begin
      ins_d = ins_q;
      if (vec_rd && any_elig) ins_d = 1'b1;
      else if (eoi)           ins_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ins_q <= 1'b0;
         irq   <= 1'b0;
         pend  <= 1'b0;
         vec   <= '0;
      end else begin
         ins_q <= ins_d;
         irq   <= any_elig && !ins_d;
         pend  <= any_elig;
         if (vec_rd) vec <= live_vec;
      end
   end

endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
   parameter int unsigned NCH   = 2,
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   tx_empty_i,
   input  logic [NCH-1:0]   ext_chg_i,
   input  logic [NCH-1:0]   rx_avail_i,
   input  logic [NCH-1:0]   rx_special_i,
   input  logic [NCH-1:0]   tx_ie_i,
   input  logic [NCH-1:0]   rx_ie_i,
   input  logic [NCH-1:0]   ext_ie_i,
   input  logic [NCH-1:0]   sav_i,
   input  logic             rx_first_i,
   input  logic [VEC_W-1:0] vec_base_i,
   input  logic             vec_rd_i,
   input  logic             eoi_i,
   output logic             irq_o,
   output logic             pend_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned CODE_W = CH_W + 2;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("intvec_prio: NCH must be at least 1");
      end
      if (VEC_W < CODE_W) begin : g_bad_vecw
         $error("intvec_prio: VEC_W too narrow for channel and cause code");
      end
   endgenerate

   logic [NCH-1:0][3:0] elig;
   logic                any_elig;
   logic                win_valid;
   logic [CH_W-1:0]     win_ch;
   logic [1:0]          win_cause;
   logic [NCH*4-1:0]    grant;
   logic [VEC_W-1:0]    live_vec;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      intvec_gate u_gate (
         .tx_empty   (tx_empty_i[g]),
         .ext_chg    (ext_chg_i[g]),
         .rx_avail   (rx_avail_i[g]),
         .rx_special (rx_special_i[g]),
         .tx_ie      (tx_ie_i[g]),
         .rx_ie      (rx_ie_i[g]),
         .ext_ie     (ext_ie_i[g]),
         .elig       (elig[g])
      );
   end

   assign any_elig = |elig;

   intvec_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
      .elig      (elig),
      .rx_first  (rx_first_i),
      .valid     (win_valid),
      .win_ch    (win_ch),
      .win_cause (win_cause),
      .grant     (grant)
   );

   // Vector composition: base, low bits replaced by {channel, cause} (R7)
   always_comb begin
      live_vec = vec_base_i;
      if (win_valid && sav_i[win_ch]) live_vec[CODE_W-1:0] = {win_ch, win_cause};
   end

   intvec_ctrl #(.VEC_W(VEC_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_elig (any_elig),
      .live_vec (live_vec),
      .vec_rd   (vec_rd_i),
      .eoi      (eoi_i),
      .irq      (irq_o),
      .pend     (pend_o),
      .vec      (vec_o)
   );

endmodule

// File: rtl/intvec_prio_chk.sv
module intvec_prio_chk #(
   parameter int unsigned NCH   = 2,
   parameter int unsigned VEC_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NCH-1:0]      tx_ie_i,
   input logic [NCH-1:0]      rx_ie_i,
   input logic [NCH-1:0]      ext_ie_i,
   input logic                vec_rd_i,
   input logic                eoi_i,
   input logic                irq_o,
   input logic                pend_o,
   input logic [VEC_W-1:0]    vec_o,
   input logic [NCH-1:0][3:0] elig,
   input logic                any_elig,
   input logic [NCH*4-1:0]    grant
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_gate
      AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !elig[g][0] || tx_ie_i[g]);                                    // R1
      AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !elig[g][1] || ext_ie_i[g]);                                   // R1
      AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !(elig[g][2] || elig[g][3]) || rx_ie_i[g]);                    // R1
   end

   AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (pend_o == $past(any_elig)));                          // R2
   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend_o);                                                // R3
   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any_elig == (grant != '0)));                  // R6
   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !$past(vec_rd_i)) |-> $stable(vec_o));                 // R8
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(vec_rd_i && any_elig)) |-> !irq_o);              // R9
   AST_EOI_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(eoi_i && !vec_rd_i && any_elig)) |-> irq_o);     // R10

endmodule

bind intvec_prio intvec_prio_chk #(.NCH(NCH), .VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_ie_i  (tx_ie_i),
   .rx_ie_i  (rx_ie_i),
   .ext_ie_i (ext_ie_i),
   .vec_rd_i (vec_rd_i),
   .eoi_i    (eoi_i),
   .irq_o    (irq_o),
   .pend_o   (pend_o),
   .vec_o    (vec_o),
   .elig     (elig),
   .any_elig (any_elig),
   .grant    (grant)
);

// File: tb/sim_intvec_prio.sv
module sim_intvec_prio;
   localparam int NCH   = 2;
   localparam int VEC_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NCH-1:0]   tx_empty, ext_chg, rx_avail, rx_special;
   logic [NCH-1:0]   tx_ie, rx_ie, ext_ie, sav;
   logic             rx_first;
   logic [VEC_W-1:0] vec_base;
   logic             vec_rd, eoi;
   logic             irq, pend;
   logic [VEC_W-1:0] vec;

   intvec_prio #(.NCH(NCH), .VEC_W(VEC_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_empty_i(tx_empty), .ext_chg_i(ext_chg), .rx_avail_i(rx_avail), .rx_special_i(rx_special),
      .tx_ie_i(tx_ie), .rx_ie_i(rx_ie), .ext_ie_i(ext_ie), .sav_i(sav),
      .rx_first_i(rx_first), .vec_base_i(vec_base), .vec_rd_i(vec_rd), .eoi_i(eoi),
      .irq_o(irq), .pend_o(pend), .vec_o(vec)
   );

   int   n_chk = 0, n_fail = 0;
   logic e_irq = 1'b0, e_pend = 1'b0, e_ins = 1'b0;
   logic [VEC_W-1:0] e_vec = '0;
   logic done = 1'b0;

   function automatic logic [3:0] gated(int ch);
      return {rx_special[ch] & rx_ie[ch], rx_avail[ch] & rx_ie[ch],
              ext_chg[ch] & ext_ie[ch], tx_empty[ch] & tx_ie[ch]};
   endfunction

   // Cause number holding rank r under the selected order (R5)
   function automatic int cause_for(int r, logic rf);
      if (rf) return (r == 0) ? 3 : (r == 1) ? 2 : (r == 2) ? 0 : 1;
      else    return (r == 0) ? 0 : (r == 1) ? 3 : (r == 2) ? 2 : 1;
   endfunction

   function automatic logic any_pending();
      logic a = 1'b0;
      for (int ch = 0; ch < NCH; ch++) a |= |gated(ch);
      return a;
   endfunction

   function automatic logic [VEC_W-1:0] model_vec();
      for (int r = 0; r < 4; r++) begin
         for (int ch = NCH - 1; ch >= 0; ch--) begin
            logic [3:0] g = gated(ch);
            if (g[cause_for(r, rx_first)]) begin
               if (sav[ch]) return {vec_base[VEC_W-1:3], 3'(ch * 4 + cause_for(r, rx_first))};
               else         return vec_base;
            end
         end
      end
      return vec_base;
   endfunction

   task automatic chk(string tag, string req, string what, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s act=%h exp=%h at %0t", req, tag, what, act, exp, $time);
      end
   endtask

   // Inputs are stable since the last falling edge; one rising edge, then compare
   task automatic step(string tag);
      logic a = any_pending();
      logic [VEC_W-1:0] lv = model_vec();
      logic ins_n = e_ins;
      if (vec_rd && a) ins_n = 1'b1;
      else if (eoi)    ins_n = 1'b0;
      @(posedge clk);
      e_ins  = ins_n;
      e_pend = a;
      e_irq  = a && !ins_n;
      if (vec_rd) e_vec = lv;
      @(negedge clk);
      chk(tag, "R2", "pend", VEC_W'(pend), VEC_W'(e_pend));
      chk(tag, "R3", "irq",  VEC_W'(irq),  VEC_W'(e_irq));
      chk(tag, "R8", "vec",  vec,          e_vec);
   endtask

   task automatic clear_causes();
      tx_empty = '0; ext_chg = '0; rx_avail = '0; rx_special = '0;
   endtask

   task automatic read_vec(string tag);
      vec_rd = 1'b1; step(tag); vec_rd = 1'b0;
   endtask

   task automatic release_eoi(string tag);
      eoi = 1'b1; step(tag); eoi = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_causes();
      tx_ie = '0; rx_ie = '0; ext_ie = '0; sav = '0;
      rx_first = 1'b0; vec_base = 8'h40; vec_rd = 1'b0; eoi = 1'b0;
      // R11: outputs quiet in reset even with activity on inputs
      repeat (3) @(negedge clk);
      tx_empty = '1; tx_ie = '1; vec_rd = 1'b1;
      @(negedge clk);
      chk("reset", "R11", "irq",  VEC_W'(irq),  '0);
      chk("reset", "R11", "pend", VEC_W'(pend), '0);
      chk("reset", "R11", "vec",  vec,          '0);
      clear_causes(); tx_ie = '0; vec_rd = 1'b0;
      rst_n = 1'b1;
      step("R11");

      tx_ie = '1; rx_ie = '1; ext_ie = '1; sav = '1;
      // R1: disabled transmit cause ignored, enabled external cause counted
      tx_ie = 2'b01; tx_empty = 2'b10;
      step("R1");
      chk("R1", "R1", "pend disabled", VEC_W'(pend), '0);
      ext_chg = 2'b01;
      step("R1");
      chk("R1", "R1", "pend enabled", VEC_W'(pend), 1);
      read_vec("R1");
      chk("R1", "R1", "vec ignores disabled", vec, 8'h41);
      release_eoi("R1");
      tx_ie = '1; clear_causes(); step("R1");

      // R6: same cause on both channels, channel A (index 1) wins
      rx_avail = 2'b11;
      read_vec("R6");
      chk("R6", "R6", "vec", vec, 8'h46);
      // R9: in service, request held low while cause persists
      step("R9"); step("R9");
      chk("R9", "R9", "irq in service", VEC_W'(irq), '0);
      // R10: read and end-of-interrupt together keep service
      vec_rd = 1'b1; eoi = 1'b1; step("R10"); vec_rd = 1'b0; eoi = 1'b0;
      chk("R10", "R10", "irq rd+eoi", VEC_W'(irq), '0);
      release_eoi("R10");
      chk("R10", "R10", "irq after eoi", VEC_W'(irq), 1);

      // R5: transmit vs receive order on channel A
      clear_causes(); tx_empty = 2'b10; rx_avail = 2'b10; rx_first = 1'b0;
      read_vec("R5");
      chk("R5", "R5", "tx first", vec, 8'h44);
      release_eoi("R5");
      rx_first = 1'b1;
      read_vec("R5");
      chk("R5", "R5", "rx first", vec, 8'h46);
      release_eoi("R5");

      // R4: codes of single causes
      clear_causes(); rx_special = 2'b01;
      read_vec("R4");
      chk("R4", "R4", "B special", vec, 8'h43);
      release_eoi("R4");
      clear_causes(); ext_chg = 2'b10;
      read_vec("R4");
      chk("R4", "R4", "A external", vec, 8'h45);
      release_eoi("R4");

      // R7: status-affects-vector off, and nothing pending
      sav = 2'b01; vec_base = 8'h9D;
      read_vec("R7");
      chk("R7", "R7", "sav off", vec, 8'h9D);
      release_eoi("R7");
      clear_causes(); sav = '1; vec_base = 8'h57;
      read_vec("R7");
      chk("R7", "R7", "none pending", vec, 8'h57);

      // R8: captured vector survives later cause changes
      rx_special = 2'b10; vec_base = 8'h20;
      read_vec("R8");
      rx_special = '0; tx_empty = 2'b01; vec_base = 8'hFF;
      step("R8"); step("R8");
      chk("R8", "R8", "held", vec, 8'h27);
      release_eoi("R8");

      // Constrained random phase
      for (int i = 0; i < 4000; i++) begin
         tx_empty   = NCH'($urandom);
         ext_chg    = NCH'($urandom) & NCH'($urandom);
         rx_avail   = NCH'($urandom);
         rx_special = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
         if (($urandom % 16) == 0) begin
            tx_ie = NCH'($urandom); rx_ie = NCH'($urandom);
            ext_ie = NCH'($urandom); sav = NCH'($urandom);
            rx_first = 1'($urandom);
            vec_base = VEC_W'($urandom);
         end
         vec_rd = (($urandom % 7) == 0);
         eoi    = (($urandom % 9) == 0);
         step("random");
      end
      vec_rd = 1'b0; eoi = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule